// File: doc/BRIEF.md
# I2C Register-File Slave with Auto-Increment

This block is a byte-wide I2C target that gives a host access to a small bank of 8-bit registers. It listens to SCL and SDA through a two-stage synchroniser and a glitch filter, recognises start, stop and repeated-start conditions, and pulls SDA low through an open-drain enable to acknowledge or to return data. The 7-bit device address is formed from a fixed six-bit prefix and one bit taken from a strap input, so two identical devices can share a bus.

After the device address with the write direction, the host sends a register-select byte that carries a 6-bit register index and an auto-increment flag. With the flag set, the data bytes that follow fill consecutive registers; with it clear, each data byte must be followed by a fresh register-select byte, so select and data bytes alternate inside one transaction. Reads use a repeated start and the read direction, and return bytes from the current pointer until the host withholds its acknowledge. The topmost register index is not storage: reading it returns the pointer itself.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset every stored register holds 00h, the pointer is 00h, auto-increment is off and SDA is not driven.
- R2: A device byte whose upper seven bits equal {prefix 3Ah, addr_strap} (bit 0 is the direction, 0 = write, 1 = read) is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: A device byte that does not match is not acknowledged; SDA stays undriven and all following bytes are ignored (not acknowledged, nothing stored) until the next start or stop.
- R4: In a register-select byte, bits 5:0 give the register index, bit 6 is the auto-increment flag and bit 7 is ignored.
- R5: With auto-increment set, each data byte is written to the pointer and the pointer then advances by one.
- R6: With auto-increment clear, each data byte is written to the pointer and the next byte of the same transaction is taken as a new register-select byte.
- R7: Every register-select byte and every data byte written to a selected device is acknowledged.
- R8: A read (repeated start or fresh start, then the read device byte) returns, MSB first, the register at the pointer; after each byte the pointer advances if auto-increment is set and stays otherwise, and it persists between transactions.
- R9: When the host does not acknowledge a read byte, the slave releases SDA and ignores SCL pulses until the next start or stop.
- R10: Register index 3Fh reads as the current pointer zero-extended to 8 bits; data written to it is discarded.
- R11: Advancing the pointer from 3Fh yields 00h, for both writes and reads.
- R12: The SDA drive changes only while the filtered SCL is low.
- R13: Pulses on SCL or SDA shorter than FILT_LEN system clocks do not disturb a transfer.
- R14: Changing addr_strap moves the device between address 74h (strap 0) and 75h (strap 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled I2C clock line |
| sda_i | input | 1 | Sampled I2C data line |
| addr_strap | input | 1 | Supplies bit 0 of the 7-bit device address |
| sda_oe | output | 1 | High to pull SDA low (open-drain enable) |

## Verification
The assertions watch, on every clock, that the SDA drive never moves while the filtered clock is high, that a rejected device stays silent, that the storage never receives a write aimed at the pointer index, that the pointer changes only on a falling clock edge and otherwise only by a step of one with wrap, and that a stop always leaves SDA released. Whether the right byte lands in the right register, whether alternating and burst writes both line up, whether the address strap and glitch filter behave, and whether a read ends cleanly on a missing acknowledge can only be shown by the bench's bus transactions reading data back through the same interface.

// File: rtl/i2c_rf_pkg.sv
// Shared types and constants for the I2C register-file slave.
// Assumes an 8-bit byte on the bus and a register-select byte whose
// low six bits index the bank.
package i2c_rf_pkg;
    localparam int BYTE_W      = 8;
    localparam int AUTOINC_BIT = 6;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transaction in progress
        ST_DEV,    // receiving the device byte
        ST_RAB,    // receiving a register-select byte
        ST_WR,     // receiving a data byte to store
        ST_RD,     // transmitting a data byte
        ST_IGN     // not addressed, wait for start or stop
    } eng_state_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
// Two-flop synchroniser followed by a stability filter for one bus line.
// The output follows the input only after FILT_LEN consecutive samples
// that differ from the current output. Idle level of the line is high.
module i2c_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], din};
    end

    // Accept a new level only after it has been seen long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= 1'b1;
            run_q <= '0;
        end else if (sync_q[1] == dout) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            dout  <= sync_q[1];
            run_q <= '0;
        end else begin
            run_q <= run_q + CW'(1);
        end
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
// Filters SCL and SDA and derives single-cycle event pulses: clock
// edges, start (SDA falls while SCL high) and stop (SDA rises while SCL
// high). Assumes the two lines never change in the same filtered cycle.
module i2c_bus_monitor #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] raw;
    logic [1:0] filt;
    logic       scl_q, sda_q;

    assign raw = {sda_i, scl_i};

    for (genvar i = 0; i < 2; i++) begin : g_line
        i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[i]),
            .dout (filt[i])
        );
    end

    assign scl_f = filt[0];
    assign sda_f = filt[1];

    // Remember last filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Event pulses, one clock wide.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_rf_bank.sv
// Register storage: one write port, one combinational read port.
// Every index except the topmost is a stored byte; the topmost index
// returns the read address itself, which is the engine's pointer.
module i2c_rf_bank #(
    parameter int AW = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  wr_addr,
    input  logic [i2c_rf_pkg::BYTE_W-1:0]  wr_data,
    input  logic [AW-1:0]                  rd_addr,
    output logic [i2c_rf_pkg::BYTE_W-1:0]  rd_data
);
    import i2c_rf_pkg::*;

    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] PTR_IDX = {AW{1'b1}};

    logic [BYTE_W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == DEPTH - 1) begin : g_ptr_slot
            assign ent_q[i] = '0;
        end else begin : g_store
            logic [BYTE_W-1:0] q;
            // Hold one register byte.
            always_ff @(posedge clk) begin
                if (!rst_n)                                q <= '0;
                else if (wr_en && wr_addr == AW'(i))       q <= wr_data;
            end
            assign ent_q[i] = q;
        end
    end

    // Read mux; the pointer index reflects the address.
    always_comb begin
        if (rd_addr == PTR_IDX) rd_data = {{(BYTE_W-AW){1'b0}}, rd_addr};
        else                    rd_data = ent_q[rd_addr];
    end
endmodule

// File: rtl/i2c_rf_engine.sv
// Byte-level I2C target protocol. Receives the device byte, register-
// select bytes and data bytes, drives acknowledges and read data, and
// owns the register pointer and auto-increment flag. All SDA drive
// updates happen on a filtered SCL falling edge. Assumes SCL is much
// slower than clk so event pulses are separated by many cycles.
module i2c_rf_engine #(
    parameter int          AW     = 6,
    parameter logic [5:0]  DEV_HI = 6'h3A
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_rise,
    input  logic                          scl_fall,
    input  logic                          start_det,
    input  logic                          stop_det,
    input  logic                          sda_f,
    input  logic                          addr_strap,
    input  logic [i2c_rf_pkg::BYTE_W-1:0] rd_data,
    output logic                          wr_en,
    output logic [AW-1:0]                 wr_addr,
    output logic [i2c_rf_pkg::BYTE_W-1:0] wr_data,
    output logic [AW-1:0]                 ptr,
    output logic                          sda_oe,
    output i2c_rf_pkg::eng_state_t        st_o
);
    import i2c_rf_pkg::*;

    localparam logic [AW-1:0] PTR_IDX = {AW{1'b1}};

    eng_state_t        st, nxt;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] rxsr, txsr;
    logic              drive, autoinc, mack;
    logic [6:0]        dev_id;

    assign dev_id = {DEV_HI, addr_strap};
    assign sda_oe = drive;
    assign st_o   = st;

    // Protocol sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            nxt     <= ST_IDLE;
            bitcnt  <= '0;
            rxsr    <= '0;
            txsr    <= '0;
            drive   <= 1'b0;
            autoinc <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                st     <= ST_DEV;
                bitcnt <= '0;
                drive  <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                bitcnt <= '0;
                drive  <= 1'b0;
            end else if (st == ST_RD) begin
                if (scl_rise) begin
                    if (bitcnt == 4'd8) begin
                        mack   <= ~sda_f;
                        bitcnt <= 4'd9;
                    end else if (bitcnt < 4'd8) begin
                        bitcnt <= bitcnt + 4'd1;
                    end
                end else if (scl_fall) begin
                    if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                        txsr  <= {txsr[BYTE_W-2:0], 1'b0};
                        drive <= ~txsr[BYTE_W-2];
                    end else if (bitcnt == 4'd8) begin
                        drive <= 1'b0;
                        if (autoinc) ptr <= ptr + AW'(1);
                    end else if (bitcnt == 4'd9) begin
                        if (mack) begin
                            txsr   <= rd_data;
                            drive  <= ~rd_data[BYTE_W-1];
                            bitcnt <= '0;
                        end else begin
                            st    <= ST_IGN;
                            drive <= 1'b0;
                        end
                    end
                end
            end else if (st == ST_DEV || st == ST_RAB || st == ST_WR) begin
                if (scl_rise && bitcnt < 4'd8) begin
                    rxsr   <= {rxsr[BYTE_W-2:0], sda_f};
                    bitcnt <= bitcnt + 4'd1;
                end else if (scl_fall && bitcnt == 4'd8) begin
                    bitcnt <= 4'd9;
                    case (st)
                        ST_DEV: begin
                            if (rxsr[7:1] == dev_id) begin
                                drive <= 1'b1;
                                nxt   <= rxsr[0] ? ST_RD : ST_RAB;
                            end else begin
                                st    <= ST_IGN;
                                drive <= 1'b0;
                            end
                        end
                        ST_RAB: begin
                            ptr     <= rxsr[AW-1:0];
                            autoinc <= rxsr[AUTOINC_BIT];
                            drive   <= 1'b1;
                            nxt     <= ST_WR;
                        end
                        default: begin
                            wr_en   <= (ptr != PTR_IDX);
                            wr_addr <= ptr;
                            wr_data <= rxsr;
                            if (autoinc) ptr <= ptr + AW'(1);
                            nxt     <= autoinc ? ST_WR : ST_RAB;
                            drive   <= 1'b1;
                        end
                    endcase
                end else if (scl_fall && bitcnt == 4'd9) begin
                    bitcnt <= '0;
                    st     <= nxt;
                    if (nxt == ST_RD) begin
                        txsr  <= rd_data;
                        drive <= ~rd_data[BYTE_W-1];
                    end else begin
                        drive <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
// Top level of the I2C register-file slave: bus monitor, protocol
// engine and register bank. SDA is open-drain: sda_oe high pulls low.
// Assumes clk runs at least ~10x faster than SCL edges are spaced.
module i2c_regfile_slave #(
    parameter int         AW       = 6,
    parameter int         FILT_LEN = 3,
    parameter logic [5:0] DEV_HI   = 6'h3A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_strap,
    output logic sda_oe
);
    import i2c_rf_pkg::*;

    logic              scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, ptr;
    logic [BYTE_W-1:0] wr_data, rd_data;
    eng_state_t        st;

    i2c_bus_monitor #(.FILT_LEN(FILT_LEN)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_rf_engine #(.AW(AW), .DEV_HI(DEV_HI)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_f     (sda_f),
        .addr_strap(addr_strap),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .sda_oe    (sda_oe),
        .st_o      (st)
    );

    i2c_rf_bank #(.AW(AW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(ptr),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/i2c_regfile_slave_chk.sv
// Property checker for the I2C register-file slave, bound to the top.
module i2c_regfile_slave_chk #(
    parameter int AW = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_f,
    input logic                   scl_fall,
    input logic                   stop_det,
    input logic                   sda_oe,
    input logic                   wr_en,
    input logic [AW-1:0]          wr_addr,
    input logic [AW-1:0]          ptr,
    input i2c_rf_pkg::eng_state_t st
);
    import i2c_rf_pkg::*;

    // R12: drive only moves after a cycle in which SCL was low
    a_r12_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_f));

    // R3: an unaddressed device never pulls SDA
    a_r3_ignored_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGN) |-> !sda_oe);

    // R10: the storage is never asked to write the pointer index
    a_r10_no_ptr_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != {AW{1'b1}}));

    // R11: outside a select byte the pointer only steps by one, wrapping
    a_r11_ptr_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr != $past(ptr)) && ($past(st) != ST_RAB)) |-> (ptr == $past(ptr) + 1'b1));

    // R8: pointer moves only on a falling SCL edge
    a_r8_ptr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> $past(scl_fall));

    // R9: a stop always leaves SDA released
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .scl_fall(scl_fall),
    .stop_det(stop_det),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .ptr     (ptr),
    .st      (st)
);

// File: tb/tb_i2c_regfile_slave.sv
module tb_i2c_regfile_slave;
    localparam int Q = 8;
    localparam int T = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_b = 1'b1;
    logic strap = 1'b0;
    logic sda_oe;
    wire  sda_line = sda_b & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int viol = 0;
    logic prev_oe = 1'b0;
    logic [7:0] rbuf [4];

    // Vector table: {register index, data}, written singly then read back.
    localparam logic [15:0] VEC [6] = '{
        16'h01A5, 16'h025A, 16'h10FF, 16'h2A00, 16'h3E81, 16'h073C
    };

    always #2 clk = ~clk;

    i2c_regfile_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .addr_strap(strap),
        .sda_oe    (sda_oe)
    );

    // R12 monitor at the ports: drive must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl) viol++;
        prev_oe = sda_oe;
    end

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl) begin
            wait_n(Q); sda_b = 1'b1; wait_n(Q); scl = 1'b1; wait_n(T);
        end
        sda_b = 1'b0; wait_n(T); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(Q); sda_b = 1'b0; wait_n(Q); scl = 1'b1; wait_n(T); sda_b = 1'b1; wait_n(T);
    endtask

    task automatic put_bit(input logic b, input logic g);
        wait_n(Q); sda_b = b;
        if (g) begin
            wait_n(3); scl = 1'b1; wait_n(1); scl = 1'b0; wait_n(Q - 4);
        end else begin
            wait_n(Q);
        end
        scl = 1'b1;
        if (g) begin
            wait_n(Q); sda_b = ~b; wait_n(1); sda_b = b; wait_n(Q - 1);
        end else begin
            wait_n(T);
        end
        scl = 1'b0;
    endtask

    task automatic get_bit(output logic v);
        wait_n(Q); sda_b = 1'b1; wait_n(Q); scl = 1'b1; wait_n(Q);
        v = sda_line; wait_n(Q); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic g, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) put_bit(b[i], g && (i == 3));
        get_bit(v);
        ack = ~v;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(~mack, 1'b0);
    endtask

    function automatic logic [7:0] dev_byte(input logic rd);
        return {6'h3A, strap, rd};
    endfunction

    task automatic write1(input logic [7:0] rab, input logic [7:0] d, input logic g,
                          output logic [2:0] acks);
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, acks[2]);
        send_byte(rab, 1'b0, acks[1]);
        send_byte(d, g, acks[0]);
        bus_stop();
    endtask

    task automatic read_from(input logic [7:0] rab, input int n);
        logic a;
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, a);
        send_byte(rab, 1'b0, a);
        bus_start();
        send_byte(dev_byte(1'b1), 1'b0, a);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [2:0] acks;
        logic [4:0] acks5;
        logic       a, v;

        wait_n(10);
        rst_n = 1'b1;
        wait_n(10);

        // R1: reset state at the port and in a register
        chk("R1 sda released after reset", {7'd0, sda_oe}, 8'h00);
        read_from(8'h05, 1);
        chk("R1 register reset value", rbuf[0], 8'h00);

        // Vector table: single write, read back (R7 acks, R8 read data)
        for (int i = 0; i < 6; i++) begin
            write1({2'b00, VEC[i][13:8]}, VEC[i][7:0], 1'b0, acks);
            chk("R7 acks single write", {5'd0, acks}, 8'h07);
            read_from({2'b00, VEC[i][13:8]}, 1);
            chk("R8 read back vector", rbuf[0], VEC[i][7:0]);
        end

        // R6: alternating select/data in one transaction
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, acks5[4]);
        send_byte(8'h05, 1'b0, acks5[3]);
        send_byte(8'h11, 1'b0, acks5[2]);
        send_byte(8'h06, 1'b0, acks5[1]);
        send_byte(8'h22, 1'b0, acks5[0]);
        bus_stop();
        chk("R2 device byte acknowledged", {7'd0, acks5[4]}, 8'h01);
        chk("R7 all select and data acked", {4'd0, acks5[3:0]}, 8'h0F);
        read_from(8'h45, 2);
        chk("R6 first alternating pair", rbuf[0], 8'h11);
        chk("R6 second alternating pair", rbuf[1], 8'h22);
        read_from(8'h05, 2);
        chk("R8 no increment first", rbuf[0], 8'h11);
        chk("R8 no increment second", rbuf[1], 8'h11);

        // R5: burst write with auto-increment
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, a);
        send_byte(8'h50, 1'b0, a);
        send_byte(8'hC1, 1'b0, a);
        send_byte(8'hC2, 1'b0, a);
        send_byte(8'hC3, 1'b0, a);
        bus_stop();
        chk("R7 last burst byte acked", {7'd0, a}, 8'h01);
        read_from(8'h50, 3);
        chk("R5 burst byte 0", rbuf[0], 8'hC1);
        chk("R5 burst byte 1", rbuf[1], 8'hC2);
        chk("R5 burst byte 2", rbuf[2], 8'hC3);

        // R4: bit 7 of the select byte is ignored
        write1(8'h92, 8'h77, 1'b0, acks);
        read_from(8'h12, 1);
        chk("R4 select bit7 ignored", rbuf[0], 8'h77);

        // R10/R11: burst across the pointer index and wrap to 00h
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, a);
        send_byte(8'h7E, 1'b0, a);
        send_byte(8'hD0, 1'b0, a);
        send_byte(8'hD1, 1'b0, a);
        send_byte(8'hD2, 1'b0, a);
        bus_stop();
        read_from(8'h7E, 3);
        chk("R11 byte before wrap", rbuf[0], 8'hD0);
        chk("R10 pointer index reads pointer", rbuf[1], 8'h3F);
        chk("R11 wrapped write to 00h", rbuf[2], 8'hD2);

        // R8: pointer persists; read without a write phase returns reg 01h
        bus_start();
        send_byte(dev_byte(1'b1), 1'b0, a);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
        chk("R8 read at persisted pointer", rbuf[0], 8'hA5);

        // R3: wrong device address ignored
        bus_start();
        send_byte({6'h3A, 1'b1, 1'b0}, 1'b0, acks[2]);
        send_byte(8'h05, 1'b0, acks[1]);
        send_byte(8'h99, 1'b0, acks[0]);
        bus_stop();
        chk("R3 no ack for foreign address", {5'd0, acks}, 8'h00);
        read_from(8'h05, 1);
        chk("R3 register untouched", rbuf[0], 8'h11);

        // R14: strap selects the address
        strap = 1'b1;
        wait_n(4);
        write1(8'h20, 8'h42, 1'b0, acks);
        chk("R14 strap-high address acked", {5'd0, acks}, 8'h07);
        read_from(8'h20, 1);
        chk("R14 data via strap-high address", rbuf[0], 8'h42);
        bus_start();
        send_byte({6'h3A, 1'b0, 1'b0}, 1'b0, a);
        bus_stop();
        chk("R14 old address rejected", {7'd0, a}, 8'h00);

        // R9: host NACK releases the bus
        bus_start();
        send_byte(dev_byte(1'b0), 1'b0, a);
        send_byte(8'h50, 1'b0, a);
        bus_start();
        send_byte(dev_byte(1'b1), 1'b0, a);
        recv_byte(1'b0, rbuf[0]);
        wait_n(Q);
        chk("R9 sda released after nack", {7'd0, sda_oe}, 8'h00);
        get_bit(v);
        chk("R9 further clocks ignored", {7'd0, v}, 8'h01);
        bus_stop();
        chk("R9 data before nack", rbuf[0], 8'hC1);

        // R13: short glitches on SCL and SDA during a data byte
        write1(8'h30, 8'h96, 1'b1, acks);
        read_from(8'h30, 1);
        chk("R13 glitches filtered", rbuf[0], 8'h96);

        chk("R12 no drive change while SCL high", viol[7:0], 8'h00);

        report();
        $finish;
    end
endmodule